// File: doc/BRIEF.md
# NAND Flash Host Bridge with Running ECC

This block sits between a simple CPU register bus and a raw 8-bit NAND flash device. Software drives the flash control lines (chip select, command latch, address latch, write protect) by writing a control register. It moves command, address and data bytes by writing or reading a data port. Each data-port access becomes a timed write-strobe or read-strobe cycle on the flash pins. Command sequencing for page programs, erases and bad blocks is left to software.

Every byte that crosses the data port, in either direction, also passes through an error-correction accumulator. The accumulator keeps a 6-bit column parity, two 8-bit line-parity bytes and a byte counter. The standard single-error-correcting Hamming code for 256-byte blocks is built this way. Software reads the accumulator back through four read-only registers and zeroes it with a write strobe before each block. A 32-bit read of the data port fetches two successive flash bytes in one bus transaction.

The CPU side is a valid/ready request channel and a valid/ready response channel. The block takes one request at a time. `req_ready` is low while a flash transfer runs and while a response waits to be taken. Every request, whether a read or a write, returns exactly one response. A response stays valid, with stable data, until `rsp_ready` is sampled high.

Top module: `nand_ecc_host`

## Requirements
- R1: After reset the flash select output is high (deselected), both latch enables are low, the write-protect output is high (not protecting), both strobes are high, the data bus is not driven, and all accumulator registers read zero.
- R2: A write to offset 0x18 stores data bits 4:0. Bit 0 or bit 4 set drives `fl_sel_n` low. Bit 1 drives `fl_cmd_latch`, bit 2 drives `fl_addr_latch`, and bit 3 set drives `fl_wprot_n` low. A read returns the stored bits in 4:0.
- R3: Bit 5 of a read at offset 0x18 shows `fl_ready` as it was a few cycles before the read, after a synchronizer. A 1 written to bit 5 is never stored.
- R4: A write to offset 0x14 produces exactly one low pulse on `fl_wr_n`. While `fl_wr_n` is low, `fl_dq_oe` is high and `fl_dq_o` carries bits 7:0 of the write data.
- R5: A byte read at offset 0x14 produces one low pulse on `fl_rd_n`, with the bus released. It returns the byte sampled in the last pulse cycle in bits 7:0, and zeros elsewhere.
- R6: A word read at offset 0x14 produces two read pulses. The first byte is returned in bits 7:0, the second in bits 23:16, and all other bits are zero.
- R7: For each transferred byte d, the column parity register (offset 0x08, bits 5:0) is XORed with the following value. Bit 0 = d0^d2^d4^d6, bit 1 = d1^d3^d5^d7, bit 2 = d0^d1^d4^d5, bit 3 = d2^d3^d6^d7, bit 4 = d0^d1^d2^d3, bit 5 = d4^d5^d6^d7.
- R8: For each transferred byte with an odd number of ones, the two internal line-parity bytes A and B change, where i is the low 8 bits of the byte count before that byte. A is XORed with ~i and B is XORed with i.
- R9: At offset 0x00, bit 2k holds A[4+k] and bit 2k+1 holds B[4+k], for k = 0..3. At offset 0x04, bit 2k holds A[k] and bit 2k+1 holds B[k].
- R10: The count register at offset 0x0C returns the low 8 bits of the number of bytes transferred since the last clear. It counts both directions and wraps from 255 to 0.
- R11: A write of any data to offset 0x10 zeroes the column parity, both line-parity bytes and the count. A read of 0x10 returns zero and changes nothing.
- R12: A read at an offset outside the seven defined ones returns zero. A write there, or a write to offsets 0x00 to 0x0C, changes neither the control nor the accumulator state.
- R13: `req_ready` stays low while a flash transfer is in progress or a response is pending. A pending response keeps `rsp_valid` high and `rsp_rdata` stable until `rsp_ready` is high.
- R14: A word write to offset 0x14 transfers only bits 7:0, as a single write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_addr | input | ADDR_W | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| fl_sel_n | output | 1 | Flash chip select, active low |
| fl_cmd_latch | output | 1 | Command latch enable |
| fl_addr_latch | output | 1 | Address latch enable |
| fl_wprot_n | output | 1 | Write protect, active low |
| fl_wr_n | output | 1 | Write strobe, active low |
| fl_rd_n | output | 1 | Read strobe, active low |
| fl_dq_o | output | 8 | Data to flash |
| fl_dq_oe | output | 1 | Output enable for fl_dq_o |
| fl_dq_i | input | 8 | Data from flash |
| fl_ready | input | 1 | Flash ready (1) / busy (0), asynchronous |

## Verification
The assertions assume that the flash never needs to drive the data bus while the block drives it. They also assume that the request fields are held stable while `req_valid` waits for `req_ready`. The bench keeps both assumptions: it changes request fields only at falling clock edges after a handshake, and its flash model drives `fl_dq_i` only on a falling read strobe. The bench also raises `fl_ready` several cycles before it reads it, so the synchronizer delay never matters. It holds `rsp_ready` low only in one directed case, to exercise back-pressure.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  // Register window byte offsets (software-visible map)
  localparam logic [5:0] OFS_LP_LO = 6'h00;
  localparam logic [5:0] OFS_LP_HI = 6'h04;
  localparam logic [5:0] OFS_COLP  = 6'h08;
  localparam logic [5:0] OFS_BCNT  = 6'h0C;
  localparam logic [5:0] OFS_CLR   = 6'h10;
  localparam logic [5:0] OFS_DATA  = 6'h14;
  localparam logic [5:0] OFS_CTRL  = 6'h18;

  // Control register bit positions
  localparam int unsigned CB_SEL0 = 0;
  localparam int unsigned CB_CMD  = 1;
  localparam int unsigned CB_ADR  = 2;
  localparam int unsigned CB_WPR  = 3;
  localparam int unsigned CB_SEL1 = 4;
  localparam int unsigned CB_RDY  = 5;
  localparam int unsigned CTL_W   = 5;

  typedef enum logic [2:0] {
    RS_LP_LO, RS_LP_HI, RS_COLP, RS_BCNT, RS_CLR, RS_DATA, RS_CTRL, RS_NONE
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD
  } seq_ph_e;

  function automatic reg_sel_e decode_ofs(input logic [5:0] a);
    case (a)
      OFS_LP_LO: return RS_LP_LO;
      OFS_LP_HI: return RS_LP_HI;
      OFS_COLP:  return RS_COLP;
      OFS_BCNT:  return RS_BCNT;
      OFS_CLR:   return RS_CLR;
      OFS_DATA:  return RS_DATA;
      OFS_CTRL:  return RS_CTRL;
      default:   return RS_NONE;
    endcase
  endfunction

  // Per-byte column parity contribution
  function automatic logic [5:0] col_bits(input logic [7:0] d);
    logic [5:0] c;
    c[0] = d[0] ^ d[2] ^ d[4] ^ d[6];
    c[1] = d[1] ^ d[3] ^ d[5] ^ d[7];
    c[2] = d[0] ^ d[1] ^ d[4] ^ d[5];
    c[3] = d[2] ^ d[3] ^ d[6] ^ d[7];
    c[4] = ^d[3:0];
    c[5] = ^d[7:4];
    return c;
  endfunction

endpackage

// File: rtl/nfc_ecc_acc.sv
module nfc_ecc_acc #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dig_vld,
  input  logic [7:0]       dig_byte,
  output logic [7:0]       lp_lo_rd,
  output logic [7:0]       lp_hi_rd,
  output logic [5:0]       colp,
  output logic [CNT_W-1:0] bcount
);
  import nfc_pkg::*;

  localparam int unsigned IDX_W = 8;
  localparam int unsigned HALF  = IDX_W / 2;

  logic [IDX_W-1:0] lp_a_q, lp_b_q;
  logic [5:0]       cp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             odd_byte;
  logic [IDX_W-1:0] idx;

  assign odd_byte = ^dig_byte;
  assign idx      = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lp_a_q <= '0;
      lp_b_q <= '0;
      cp_q   <= '0;
      cnt_q  <= '0;
    end else if (dig_vld) begin
      cp_q  <= cp_q ^ col_bits(dig_byte);
      cnt_q <= cnt_q + 1'b1;
      if (odd_byte) begin
        lp_a_q <= lp_a_q ^ ~idx;
        lp_b_q <= lp_b_q ^ idx;
      end
    end
  end

  // Interleaved readback: upper halves into the low register, lower halves into the high one
  for (genvar k = 0; k < HALF; k++) begin : g_ilv
    assign lp_lo_rd[2*k]   = lp_a_q[HALF+k];
    assign lp_lo_rd[2*k+1] = lp_b_q[HALF+k];
    assign lp_hi_rd[2*k]   = lp_a_q[k];
    assign lp_hi_rd[2*k+1] = lp_b_q[k];
  end

  assign colp   = cp_q;
  assign bcount = cnt_q;

endmodule

// File: rtl/nfc_pin_seq.sv
module nfc_pin_seq #(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_mode,
  input  logic       two_bytes,
  input  logic [7:0] wr_byte,
  input  logic [7:0] din,
  output logic       done,
  output logic       dig_vld,
  output logic [7:0] dig_byte,
  output logic [7:0] cap0,
  output logic [7:0] cap1,
  output logic       wr_n,
  output logic       rd_n,
  output logic [7:0] dq_out,
  output logic       dq_oe
);
  import nfc_pkg::*;

  localparam int unsigned MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int unsigned TMR_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] T_PULSE = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] T_HOLD  = TMR_W'(HOLD_CYC - 1);

  seq_ph_e          ph_q, ph_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             sec_q, sec_d;
  logic             rdm_q, rdm_d;
  logic             two_q, two_d;
  logic [7:0]       wb_q, wb_d;
  logic             tmr_zero;
  logic             wr_n_q, rd_n_q, oe_q;
  logic [7:0]       cap0_q, cap1_q;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    ph_d  = ph_q;
    tmr_d = tmr_q;
    sec_d = sec_q;
    rdm_d = rdm_q;
    two_d = two_q;
    wb_d  = wb_q;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_SETUP;
          tmr_d = T_SETUP;
          sec_d = 1'b0;
          rdm_d = rd_mode;
          two_d = two_bytes;
          wb_d  = wr_byte;
        end
      end
      PH_SETUP: begin
        if (tmr_zero) begin
          ph_d  = PH_PULSE;
          tmr_d = T_PULSE;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      PH_PULSE: begin
        if (tmr_zero) begin
          ph_d  = PH_HOLD;
          tmr_d = T_HOLD;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: begin
        if (tmr_zero) begin
          if (two_q && !sec_q) begin
            ph_d  = PH_SETUP;
            tmr_d = T_SETUP;
            sec_d = 1'b1;
          end else begin
            ph_d = PH_IDLE;
          end
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      tmr_q  <= '0;
      sec_q  <= 1'b0;
      rdm_q  <= 1'b0;
      two_q  <= 1'b0;
      wb_q   <= '0;
      wr_n_q <= 1'b1;
      rd_n_q <= 1'b1;
      oe_q   <= 1'b0;
      cap0_q <= '0;
      cap1_q <= '0;
    end else begin
      ph_q   <= ph_d;
      tmr_q  <= tmr_d;
      sec_q  <= sec_d;
      rdm_q  <= rdm_d;
      two_q  <= two_d;
      wb_q   <= wb_d;
      // Pins follow the next phase so they line up with ph_q from a register
      wr_n_q <= !((ph_d == PH_PULSE) && !rdm_d);
      rd_n_q <= !((ph_d == PH_PULSE) && rdm_d);
      oe_q   <= (ph_d != PH_IDLE) && !rdm_d;
      if ((ph_q == PH_PULSE) && tmr_zero && rdm_q) begin
        if (sec_q) cap1_q <= din;
        else       cap0_q <= din;
      end
    end
  end

  assign dig_vld  = (ph_q == PH_HOLD) && tmr_zero;
  assign done     = dig_vld && !(two_q && !sec_q);
  assign dig_byte = rdm_q ? (sec_q ? cap1_q : cap0_q) : wb_q;
  assign cap0     = cap0_q;
  assign cap1     = cap1_q;
  assign wr_n     = wr_n_q;
  assign rd_n     = rd_n_q;
  assign dq_oe    = oe_q;
  assign dq_out   = wb_q;

endmodule

// File: rtl/nand_ecc_host.sv
module nand_ecc_host #(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned PULSE_CYC   = 2,
  parameter int unsigned HOLD_CYC    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              fl_sel_n,
  output logic              fl_cmd_latch,
  output logic              fl_addr_latch,
  output logic              fl_wprot_n,
  output logic              fl_wr_n,
  output logic              fl_rd_n,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_i,
  input  logic              fl_ready
);
  import nfc_pkg::*;

  localparam int unsigned OFS_BITS = 6;

  logic [CTL_W-1:0] ctl_q;
  logic             busy_q, rd_q, word_q;
  logic             rsp_valid_q;
  logic [31:0]      rsp_data_q;
  logic             in_window;
  reg_sel_e         sel;
  logic             accept;
  logic             rdy_live;
  logic [31:0]      reg_rdata;
  logic [31:0]      io_rdata;

  logic             seq_done, dig_vld;
  logic [7:0]       dig_byte, cap0, cap1;
  logic             ecc_clr;
  logic [7:0]       lp_lo_rd, lp_hi_rd;
  logic [5:0]       colp;
  logic [CNT_W-1:0] ecc_bcount;

  // Window check: upper address bits beyond the 64-byte map must be zero
  if (ADDR_W > OFS_BITS) begin : g_wide
    assign in_window = (req_addr[ADDR_W-1:OFS_BITS] == '0);
    assign sel = in_window ? decode_ofs(req_addr[OFS_BITS-1:0]) : RS_NONE;
  end else begin : g_narrow
    assign in_window = 1'b1;
    assign sel = decode_ofs(OFS_BITS'(req_addr));
  end

  // Ready/busy input synchronizer
  logic [SYNC_STAGES-1:0] rdy_sync_q;
  if (SYNC_STAGES > 1) begin : g_sync_n
    always_ff @(posedge clk) begin
      if (!rst_n) rdy_sync_q <= '0;
      else        rdy_sync_q <= {rdy_sync_q[SYNC_STAGES-2:0], fl_ready};
    end
  end else begin : g_sync_1
    always_ff @(posedge clk) begin
      if (!rst_n) rdy_sync_q <= '0;
      else        rdy_sync_q <= fl_ready;
    end
  end
  assign rdy_live = rdy_sync_q[SYNC_STAGES-1];

  assign req_ready = !busy_q && !rsp_valid_q;
  assign accept    = req_valid && req_ready;
  assign ecc_clr   = accept && req_write && (sel == RS_CLR);

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RS_LP_LO: reg_rdata[7:0] = lp_lo_rd;
      RS_LP_HI: reg_rdata[7:0] = lp_hi_rd;
      RS_COLP:  reg_rdata[5:0] = colp;
      RS_BCNT:  reg_rdata[7:0] = ecc_bcount[7:0];
      RS_CTRL: begin
        reg_rdata[CTL_W-1:0] = ctl_q;
        reg_rdata[CB_RDY]    = rdy_live;
      end
      default:  reg_rdata = '0;
    endcase
  end

  assign io_rdata = word_q ? {8'h00, cap1, 8'h00, cap0} : {24'h0, cap0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      busy_q      <= 1'b0;
      rd_q        <= 1'b0;
      word_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      if (accept) begin
        if (sel == RS_DATA) begin
          busy_q <= 1'b1;
          rd_q   <= !req_write;
          word_q <= req_word && !req_write;
        end else begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= req_write ? 32'h0 : reg_rdata;
          if (req_write && (sel == RS_CTRL)) ctl_q <= req_wdata[CTL_W-1:0];
        end
      end
      if (busy_q && seq_done) begin
        busy_q      <= 1'b0;
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_q ? io_rdata : 32'h0;
      end
    end
  end

  nfc_pin_seq #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && (sel == RS_DATA)),
    .rd_mode   (!req_write),
    .two_bytes (!req_write && req_word),
    .wr_byte   (req_wdata[7:0]),
    .din       (fl_dq_i),
    .done      (seq_done),
    .dig_vld   (dig_vld),
    .dig_byte  (dig_byte),
    .cap0      (cap0),
    .cap1      (cap1),
    .wr_n      (fl_wr_n),
    .rd_n      (fl_rd_n),
    .dq_out    (fl_dq_o),
    .dq_oe     (fl_dq_oe)
  );

  nfc_ecc_acc #(.CNT_W(CNT_W)) u_ecc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ecc_clr),
    .dig_vld  (dig_vld),
    .dig_byte (dig_byte),
    .lp_lo_rd (lp_lo_rd),
    .lp_hi_rd (lp_hi_rd),
    .colp     (colp),
    .bcount   (ecc_bcount)
  );

  assign fl_sel_n      = !(ctl_q[CB_SEL0] || ctl_q[CB_SEL1]);
  assign fl_cmd_latch  = ctl_q[CB_CMD];
  assign fl_addr_latch = ctl_q[CB_ADR];
  assign fl_wprot_n    = !ctl_q[CB_WPR];
  assign rsp_valid     = rsp_valid_q;
  assign rsp_rdata     = rsp_data_q;

endmodule

// File: rtl/nfc_host_chk.sv
module nfc_host_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              fl_wr_n,
  input logic              fl_rd_n,
  input logic              fl_dq_oe,
  input logic [CNT_W-1:0]  ecc_bcount
);
  import nfc_pkg::*;

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_wr_n && !fl_rd_n));

  p_wr_drives_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_wr_n |-> fl_dq_oe);

  p_rd_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rd_n |-> !fl_dq_oe);

  p_rsp_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_one_outstanding_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_clear_zeroes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (req_addr == ADDR_W'(OFS_CLR)))
      |=> (ecc_bcount == '0));

endmodule

bind nand_ecc_host nfc_host_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .fl_wr_n    (fl_wr_n),
  .fl_rd_n    (fl_rd_n),
  .fl_dq_oe   (fl_dq_oe),
  .ecc_bcount (ecc_bcount)
);

// File: tb/nand_ecc_host_test.sv
module nand_ecc_host_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        fl_sel_n, fl_cmd_latch, fl_addr_latch, fl_wprot_n;
  logic        fl_wr_n, fl_rd_n, fl_dq_oe;
  logic [7:0]  fl_dq_o;
  logic [7:0]  fl_dq_i = 8'h00;
  logic        fl_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  nand_ecc_host uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .fl_sel_n(fl_sel_n), .fl_cmd_latch(fl_cmd_latch), .fl_addr_latch(fl_addr_latch),
    .fl_wprot_n(fl_wprot_n), .fl_wr_n(fl_wr_n), .fl_rd_n(fl_rd_n),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ready(fl_ready)
  );

  // Flash model: logs written bytes, serves queued bytes on read strobes
  logic [7:0] wlog [0:1023];
  int         wcnt = 0;
  logic [7:0] rq [0:1023];
  int         rq_wr = 0;
  int         rq_rd = 0;
  int         rd_pulses = 0;

  always @(posedge fl_wr_n) if (rst_n) begin
    wlog[wcnt % 1024] = fl_dq_o;
    wcnt++;
  end

  always @(negedge fl_rd_n) if (rst_n) begin
    fl_dq_i = rq[rq_rd % 1024];
    rq_rd++;
    rd_pulses++;
  end

  // Reference accumulator
  logic [5:0]  m_cp  = '0;
  logic [7:0]  m_lpa = '0;
  logic [7:0]  m_lpb = '0;
  logic [31:0] m_cnt = '0;

  function automatic logic [5:0] colc(input logic [7:0] d);
    return {d[7]^d[6]^d[5]^d[4], d[3]^d[2]^d[1]^d[0],
            d[7]^d[6]^d[3]^d[2], d[5]^d[4]^d[1]^d[0],
            d[7]^d[5]^d[3]^d[1], d[6]^d[4]^d[2]^d[0]};
  endfunction

  function automatic logic [7:0] ilv(input logic [7:0] a, input logic [7:0] b, input bit upper);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) begin
      r[2*k]   = upper ? a[4+k] : a[k];
      r[2*k+1] = upper ? b[4+k] : b[k];
    end
    return r;
  endfunction

  task automatic m_dig(input logic [7:0] b);
    m_cp = m_cp ^ colc(b);
    if (^b) begin
      m_lpa = m_lpa ^ ~m_cnt[7:0];
      m_lpb = m_lpb ^ m_cnt[7:0];
    end
    m_cnt = m_cnt + 1;
  endtask

  task automatic m_clear();
    m_cp = '0; m_lpa = '0; m_lpb = '0; m_cnt = '0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input bit wd, input logic [5:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic io_write(input logic [7:0] b, input bit wd, input logic [23:0] hi);
    logic [31:0] q;
    int w0;
    w0 = wcnt;
    bus(1'b1, wd, 6'h14, {hi, b}, q);
    chk(wcnt == w0 + 1, wd ? "R14 one strobe" : "R4 one strobe", wcnt - w0, 1);
    chk(wlog[w0 % 1024] == b, wd ? "R14 low byte" : "R4 bus byte", wlog[w0 % 1024], b);
    m_dig(b);
  endtask

  task automatic io_read(input bit wd);
    logic [31:0] q, exp;
    logic [7:0]  b0, b1;
    int p0;
    b0 = 8'($urandom); b1 = 8'($urandom);
    rq[rq_wr % 1024] = b0; rq_wr++;
    if (wd) begin rq[rq_wr % 1024] = b1; rq_wr++; end
    p0 = rd_pulses;
    bus(1'b0, wd, 6'h14, 32'h0, q);
    exp = wd ? {8'h00, b1, 8'h00, b0} : {24'h0, b0};
    chk(q == exp, wd ? "R6 word read" : "R5 byte read", q, exp);
    chk(rd_pulses == p0 + (wd ? 2 : 1), wd ? "R6 two pulses" : "R5 one pulse", rd_pulses - p0, wd ? 2 : 1);
    m_dig(b0);
    if (wd) m_dig(b1);
  endtask

  task automatic check_ecc(input string tag);
    logic [31:0] q;
    bus(1'b0, 1'b0, 6'h00, 32'h0, q);
    chk(q == {24'h0, ilv(m_lpa, m_lpb, 1)}, {tag, " R9 R8 lp low"}, q, {24'h0, ilv(m_lpa, m_lpb, 1)});
    bus(1'b0, 1'b0, 6'h04, 32'h0, q);
    chk(q == {24'h0, ilv(m_lpa, m_lpb, 0)}, {tag, " R9 R8 lp high"}, q, {24'h0, ilv(m_lpa, m_lpb, 0)});
    bus(1'b0, 1'b0, 6'h08, 32'h0, q);
    chk(q == {26'h0, m_cp}, {tag, " R7 colp"}, q, {26'h0, m_cp});
    bus(1'b0, 1'b0, 6'h0C, 32'h0, q);
    chk(q == {24'h0, m_cnt[7:0]}, {tag, " R10 count"}, q, {24'h0, m_cnt[7:0]});
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    logic [31:0] q, keep;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(fl_sel_n && !fl_cmd_latch && !fl_addr_latch && fl_wprot_n,
        "R1 ctrl pins", {fl_sel_n, fl_cmd_latch, fl_addr_latch, fl_wprot_n}, 4'b1001);
    chk(fl_wr_n && fl_rd_n && !fl_dq_oe, "R1 strobes", {fl_wr_n, fl_rd_n, fl_dq_oe}, 3'b110);
    chk(req_ready && !rsp_valid, "R1 handshake idle", {req_ready, rsp_valid}, 2'b10);
    check_ecc("R1");

    // R2 / R3 control register
    bus(1'b1, 1'b0, 6'h18, 32'h3F, q);
    chk(!fl_sel_n && fl_cmd_latch && fl_addr_latch && !fl_wprot_n,
        "R2 pins all set", {fl_sel_n, fl_cmd_latch, fl_addr_latch, fl_wprot_n}, 4'b0110);
    bus(1'b0, 1'b0, 6'h18, 32'h0, q);
    chk(q == 32'h1F, "R3 ready bit not stored", q, 32'h1F);
    fl_ready = 1'b1;
    repeat (5) @(negedge clk);
    bus(1'b0, 1'b0, 6'h18, 32'h0, q);
    chk(q == 32'h3F, "R3 live ready bit", q, 32'h3F);
    bus(1'b1, 1'b0, 6'h18, 32'h12, q);
    chk(!fl_sel_n && fl_cmd_latch && !fl_addr_latch && fl_wprot_n,
        "R2 second select", {fl_sel_n, fl_cmd_latch, fl_addr_latch, fl_wprot_n}, 4'b0101);
    bus(1'b1, 1'b0, 6'h18, 32'h01, q);
    chk(!fl_sel_n && !fl_cmd_latch, "R2 first select", {fl_sel_n, fl_cmd_latch}, 2'b00);

    // Directed corner bytes, then random traffic
    bus(1'b1, 1'b0, 6'h10, 32'hDEAD_BEEF, q); m_clear();
    io_write(8'h00, 1'b0, 24'h0);
    io_write(8'h01, 1'b0, 24'h0);
    io_write(8'hFF, 1'b0, 24'h0);
    io_write(8'h80, 1'b0, 24'h0);
    check_ecc("directed");
    for (int i = 0; i < 60; i++) begin
      case ($urandom % 4)
        0: io_write(8'($urandom), 1'b0, 24'h0);
        1: io_write(8'($urandom), 1'b1, 24'($urandom));
        2: io_read(1'b0);
        default: io_read(1'b1);
      endcase
    end
    check_ecc("random");

    // R10 wrap of the counter past 255
    bus(1'b1, 1'b0, 6'h10, 32'h0, q); m_clear();
    for (int i = 0; i < 260; i++) io_write(8'($urandom), 1'b0, 24'h0);
    check_ecc("wrap");

    // R11 read of clear offset has no effect; write of any value clears
    bus(1'b0, 1'b0, 6'h10, 32'h0, q);
    chk(q == 32'h0, "R11 clear reads zero", q, 0);
    check_ecc("R11 after clear read");
    bus(1'b1, 1'b1, 6'h10, 32'hFFFF_FFFF, q); m_clear();
    check_ecc("R11 after clear");

    // R12 unmapped and read-only offsets
    io_read(1'b0); io_write(8'h5A, 1'b0, 24'h0);
    bus(1'b0, 1'b0, 6'h1C, 32'h0, q);
    chk(q == 32'h0, "R12 unmapped read 1C", q, 0);
    bus(1'b0, 1'b1, 6'h3C, 32'h0, q);
    chk(q == 32'h0, "R12 unmapped read 3C", q, 0);
    bus(1'b0, 1'b0, 6'h02, 32'h0, q);
    chk(q == 32'h0, "R12 unaligned read", q, 0);
    bus(1'b1, 1'b0, 6'h1C, 32'hFF, q);
    bus(1'b1, 1'b0, 6'h00, 32'hFF, q);
    bus(1'b1, 1'b0, 6'h0C, 32'hFF, q);
    bus(1'b1, 1'b0, 6'h16, 32'hFF, q);
    check_ecc("R12 after ignored writes");
    bus(1'b0, 1'b0, 6'h18, 32'h0, q);
    chk(q == 32'h21, "R12 control unchanged", q, 32'h21);

    // R13 back-pressure on the response
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b0; req_addr = 6'h18;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    keep = rsp_rdata;
    repeat (5) @(negedge clk);
    chk(rsp_valid && !req_ready, "R13 response held", {rsp_valid, req_ready}, 2'b10);
    chk(rsp_rdata == keep && keep == 32'h21, "R13 data stable", rsp_rdata, 32'h21);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R13 response taken", {rsp_valid, req_ready}, 2'b01);

    finish_up();
  end

endmodule